// File: doc/BRIEF.md
# Local-to-Wishbone Master Bridge

This block turns a minimal local register port into single classic Wishbone bus cycles. A requester raises a write strobe or a read strobe for one clock, together with an address and, for a write, the data. The bridge registers that request and presents it on the bus one clock later. It holds the bus cycle open until the slave terminates it with ACK or ERR, and then reports completion back to the requester.

The local side sees a one-clock acknowledge for every accepted request. An error flag comes with that acknowledge when the slave ended the cycle with ERR. After a successful read, the returned data stays on a local output until the next successful read. A request that sets both strobes at once is illegal and is dropped. Strobes that arrive while a cycle is open are ignored, so the requester must wait for the acknowledge before it issues the next request. Address and data widths are parameters, both 8 bits by default.

Top module: `lbus_wb_master`

## Requirements
- R1: While the synchronous, active-high reset is sampled high, wb_cyc, wb_stb, wb_we, wb_adr, wb_dat_o, loc_ack, loc_err and loc_rdata are all driven to zero from the next clock edge.
- R2: When no cycle is open and exactly one of loc_wr and loc_rd is high at a clock edge, wb_cyc and wb_stb are both high after that edge.
- R3: When loc_wr and loc_rd are both high at an edge with no cycle open, no bus cycle starts and wb_cyc stays low.
- R4: During a cycle, wb_adr equals the loc_addr captured on the request edge and stays unchanged until the cycle ends.
- R5: During a cycle started by loc_wr, wb_we is 1 and wb_dat_o equals the captured loc_wdata. During a cycle started by loc_rd, wb_we is 0.
- R6: wb_cyc and wb_stb stay high until wb_ack or wb_err is sampled high, and both are low after that edge.
- R7: loc_ack is high for exactly the one clock after the edge at which the cycle ended, for ACK and ERR endings alike.
- R8: On a read ended by wb_ack with wb_err low, loc_rdata takes the wb_dat_i value sampled on that edge. loc_rdata keeps that value until the next such read.
- R9: loc_err is high together with loc_ack when the cycle ended with wb_err high. In that case loc_rdata does not change.
- R10: loc_wr and loc_rd pulses that arrive while a cycle is open have no effect: the open cycle's address and direction are unchanged, and no further cycle follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| loc_wr | input | 1 | Local write strobe, one clock |
| loc_rd | input | 1 | Local read strobe, one clock |
| loc_addr | input | AW | Local address, valid with a strobe |
| loc_wdata | input | DW | Local write data, valid with loc_wr |
| loc_rdata | output | DW | Data from the last successful read |
| loc_ack | output | 1 | Completion pulse |
| loc_err | output | 1 | Completion was an error |
| wb_cyc | output | 1 | Bus cycle active |
| wb_stb | output | 1 | Bus strobe |
| wb_we | output | 1 | Bus write enable |
| wb_adr | output | AW | Bus address |
| wb_dat_o | output | DW | Bus write data |
| wb_dat_i | input | DW | Bus read data |
| wb_ack | input | 1 | Bus normal termination |
| wb_err | input | 1 | Bus error termination |

## Verification
The assertions check the following on every clock: a single strobe opens a cycle, a double strobe opens none, the address holds steady through wait states, termination drops the cycle and produces exactly one acknowledge pulse, an error flag always comes with an acknowledge, and read data changes only on a clean read termination. Only the bench scenarios can show that written data reaches a slave and reads back intact over several wait-state settings and at the address extremes. They also show that a strobe injected mid-cycle leaves no trace in the slave's contents, and that an error ending preserves the previous read value.

// File: rtl/lbus_wb_master.sv
module lbus_wb_master #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          loc_wr,
  input  logic          loc_rd,
  input  logic [AW-1:0] loc_addr,
  input  logic [DW-1:0] loc_wdata,
  output logic [DW-1:0] loc_rdata,
  output logic          loc_ack,
  output logic          loc_err,
  output logic          wb_cyc,
  output logic          wb_stb,
  output logic          wb_we,
  output logic [AW-1:0] wb_adr,
  output logic [DW-1:0] wb_dat_o,
  input  logic [DW-1:0] wb_dat_i,
  input  logic          wb_ack,
  input  logic          wb_err
);

  logic start, done, rd_ok;

  assign start  = ~wb_cyc & (loc_wr ^ loc_rd);
  assign done   = wb_cyc & (wb_ack | wb_err);
  assign rd_ok  = done & wb_ack & ~wb_err & ~wb_we;
  assign wb_stb = wb_cyc;

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_cyc    <= 1'b0;
      wb_we     <= 1'b0;
      wb_adr    <= '0;
      wb_dat_o  <= '0;
      loc_ack   <= 1'b0;
      loc_err   <= 1'b0;
      loc_rdata <= '0;
    end else begin
      loc_ack <= done;
      loc_err <= done & wb_err;
      if (done) begin
        wb_cyc <= 1'b0;
      end else if (start) begin
        wb_cyc <= 1'b1;
        wb_we  <= loc_wr;
        wb_adr <= loc_addr;
        if (loc_wr) wb_dat_o <= loc_wdata;
      end
      if (rd_ok) loc_rdata <= wb_dat_i;
    end
  end

endmodule

// File: rtl/lbus_wb_master_chk.sv
module lbus_wb_master_chk #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          loc_wr,
  input logic          loc_rd,
  input logic [DW-1:0] loc_rdata,
  input logic          loc_ack,
  input logic          loc_err,
  input logic          wb_cyc,
  input logic          wb_stb,
  input logic          wb_we,
  input logic [AW-1:0] wb_adr,
  input logic [DW-1:0] wb_dat_i,
  input logic          wb_ack,
  input logic          wb_err
);

  a_r2_open: assert property (@(posedge clk) disable iff (rst)
    (!wb_cyc && (loc_wr ^ loc_rd)) |=> (wb_cyc && wb_stb));

  a_r3_illegal: assert property (@(posedge clk) disable iff (rst)
    (!wb_cyc && loc_wr && loc_rd) |=> !wb_cyc);

  a_r4_adr_hold: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc && !wb_ack && !wb_err) |=> (wb_cyc && $stable(wb_adr) && $stable(wb_we)));

  a_r6_drop: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc && (wb_ack || wb_err)) |=> (!wb_cyc && !wb_stb && loc_ack));

  a_r7_single: assert property (@(posedge clk) disable iff (rst)
    loc_ack |=> !loc_ack);

  a_r7_cause: assert property (@(posedge clk) disable iff (rst)
    !wb_cyc |=> !loc_ack);

  a_r9_err_with_ack: assert property (@(posedge clk) disable iff (rst)
    loc_err |-> loc_ack);

  a_r8_capture: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc && !wb_we && wb_ack && !wb_err) |=> (loc_rdata == $past(wb_dat_i)));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !(wb_cyc && !wb_we && wb_ack && !wb_err) |=> $stable(loc_rdata));

endmodule

bind lbus_wb_master lbus_wb_master_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst(rst), .loc_wr(loc_wr), .loc_rd(loc_rd),
  .loc_rdata(loc_rdata), .loc_ack(loc_ack), .loc_err(loc_err),
  .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
  .wb_dat_i(wb_dat_i), .wb_ack(wb_ack), .wb_err(wb_err)
);

// File: tb/lbus_wb_master_tb_top.sv
`timescale 1ns/1ps
module lbus_wb_master_tb_top;
  localparam int AW = 8;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic loc_wr = 1'b0, loc_rd = 1'b0;
  logic [AW-1:0] loc_addr = '0;
  logic [DW-1:0] loc_wdata = '0;
  logic [DW-1:0] loc_rdata;
  logic loc_ack, loc_err;
  logic wb_cyc, wb_stb, wb_we;
  logic [AW-1:0] wb_adr;
  logic [DW-1:0] wb_dat_o;
  logic [DW-1:0] wb_dat_i = '0;
  logic wb_ack = 1'b0, wb_err = 1'b0;

  int compared = 0;
  int mismatched = 0;

  always #2.5 clk = ~clk;

  lbus_wb_master #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .loc_wr(loc_wr), .loc_rd(loc_rd),
    .loc_addr(loc_addr), .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
    .loc_ack(loc_ack), .loc_err(loc_err), .wb_cyc(wb_cyc), .wb_stb(wb_stb),
    .wb_we(wb_we), .wb_adr(wb_adr), .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i),
    .wb_ack(wb_ack), .wb_err(wb_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Slave model
  logic [DW-1:0] mem [0:(1<<AW)-1];
  int wait_cfg = 0;
  int wcnt = 0;
  int err_addr = -1;
  initial for (int i = 0; i < (1<<AW); i++) mem[i] = '0;

  always @(negedge clk) begin
    if (!wb_cyc) begin
      wb_ack <= 1'b0; wb_err <= 1'b0; wcnt <= 0; wb_dat_i <= 8'h3C;
    end else if (!wb_ack && !wb_err) begin
      if (wcnt >= wait_cfg) begin
        if (int'(wb_adr) == err_addr) wb_err <= 1'b1;
        else begin
          wb_ack <= 1'b1;
          if (wb_we) begin mem[wb_adr] = wb_dat_o; wb_dat_i <= 8'h00; end
          else wb_dat_i <= mem[wb_adr];
        end
      end else wcnt <= wcnt + 1;
    end
  end

  // Cycle reference model
  bit started = 0;
  bit m_busy = 0, m_we = 0, m_ack = 0, m_err = 0;
  int m_adr = 0, m_dat = 0, m_rdata = 0;
  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_busy = 0; m_we = 0; m_ack = 0; m_err = 0; m_adr = 0; m_dat = 0; m_rdata = 0;
    end else begin
      m_ack = 0; m_err = 0;
      if (m_busy) begin
        if (wb_ack || wb_err) begin
          m_busy = 0; m_ack = 1; m_err = wb_err;
          if (wb_ack && !wb_err && !m_we) m_rdata = int'(wb_dat_i);
        end
      end else if (loc_wr != loc_rd) begin
        m_busy = 1; m_we = loc_wr; m_adr = int'(loc_addr);
        if (loc_wr) m_dat = int'(loc_wdata);
      end
    end
  end

  always @(negedge clk) if (started) begin
    check("R2 wb_cyc", 32'(wb_cyc), 32'(m_busy));
    check("R6 wb_stb", 32'(wb_stb), 32'(m_busy));
    check("R7 loc_ack", 32'(loc_ack), 32'(m_ack));
    check("R9 loc_err", 32'(loc_err), 32'(m_err));
    check("R8 loc_rdata", 32'(loc_rdata), 32'(m_rdata));
    if (m_busy) begin
      check("R4 wb_adr", 32'(wb_adr), 32'(m_adr));
      check("R5 wb_we", 32'(wb_we), 32'(m_we));
      if (m_we) check("R5 wb_dat_o", 32'(wb_dat_o), 32'(m_dat));
    end
  end

  task automatic pulse(input logic w, input logic r, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    loc_wr = w; loc_rd = r; loc_addr = a; loc_wdata = d;
    @(negedge clk);
    loc_wr = 0; loc_rd = 0; loc_addr = '0; loc_wdata = '0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!loc_ack && n < 60) begin @(negedge clk); n++; end
    check("R7 completion seen", 32'(loc_ack), 32'd1);
  endtask

  logic [DW-1:0] shadow [0:3];
  logic [AW-1:0] addrs [0:3];

  initial begin
    addrs[0] = 8'h00; addrs[1] = 8'hFF; addrs[2] = 8'h12; addrs[3] = 8'h5A;
    shadow[0] = 8'hA5; shadow[1] = 8'h5A; shadow[2] = 8'h81; shadow[3] = 8'h7E;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 wb_cyc", 32'(wb_cyc), 0);
    check("R1 wb_we", 32'(wb_we), 0);
    check("R1 wb_adr", 32'(wb_adr), 0);
    check("R1 wb_dat_o", 32'(wb_dat_o), 0);
    check("R1 loc_ack", 32'(loc_ack), 0);
    check("R1 loc_rdata", 32'(loc_rdata), 0);
    rst = 0;
    // writes with varying wait states
    for (int i = 0; i < 4; i++) begin
      wait_cfg = i;
      pulse(1, 0, addrs[i], shadow[i]);
      wait_done();
      check("R9 no error on write", 32'(loc_err), 0);
      check("R5 slave stored data", 32'(mem[addrs[i]]), 32'(shadow[i]));
    end
    // reads back
    for (int i = 3; i >= 0; i--) begin
      wait_cfg = 3 - i;
      pulse(0, 1, addrs[i], '0);
      wait_done();
      check("R8 read data", 32'(loc_rdata), 32'(shadow[i]));
    end
    // error endings
    err_addr = 8'h77; wait_cfg = 1;
    pulse(1, 0, 8'h77, 8'hEE);
    wait_done();
    check("R9 write error flag", 32'(loc_err), 1);
    pulse(0, 1, 8'h77, '0);
    wait_done();
    check("R9 read error flag", 32'(loc_err), 1);
    check("R9 rdata kept", 32'(loc_rdata), 32'(shadow[0]));
    err_addr = -1;
    // illegal double strobe
    pulse(1, 1, 8'h40, 8'h99);
    for (int i = 0; i < 4; i++) begin
      check("R3 no cycle", 32'(wb_cyc), 0);
      @(negedge clk);
    end
    check("R3 slave untouched", 32'(mem[8'h40]), 0);
    // strobes while busy
    wait_cfg = 4;
    pulse(0, 1, 8'h12, '0);
    loc_wr = 1; loc_addr = 8'h34; loc_wdata = 8'hAA;
    @(negedge clk);
    loc_wr = 0; loc_rd = 1; loc_addr = 8'h00;
    @(negedge clk);
    loc_rd = 0; loc_addr = '0; loc_wdata = '0;
    check("R10 adr unchanged", 32'(wb_adr), 32'h12);
    check("R10 dir unchanged", 32'(wb_we), 0);
    wait_done();
    check("R10 first read data", 32'(loc_rdata), 32'(shadow[2]));
    repeat (3) begin
      @(negedge clk);
      check("R10 no follow-up cycle", 32'(wb_cyc), 0);
    end
    check("R10 ignored write absent", 32'(mem[8'h34]), 0);
    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule